// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Alternate-Function Arbitration

This block controls a byte-wide general-purpose I/O port whose pins are shared with other on-chip functions. For every pin it keeps an output data bit and a direction bit, and it works out which function owns the pin: an external interrupt request input can claim one dedicated pin, a PWM channel can claim any pin, and the GPIO registers get what is left. It drives one output value and one output-enable per pin to the pad ring.

The pad inputs are brought into the clock domain by a two-flop synchronizer. The synchronized values feed register read-back, the edge detectors behind the per-pin interrupt flags, the interrupt-request output and the external trigger output. One pin can act as a switchable supply. An over-current event from outside the block latches a flag, which pulls that pin low and can raise its own interrupt.

Software reaches the block through a simple single-cycle register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is held and after it is released, all direction, data, interrupt-enable, polarity and control bits are 0, all pin flags and the over-current flag are 0, every `pin_oe_o` bit is 0 while no PWM channel is enabled, and `pin_irq_o` and `oc_irq_o` are 0.
- R2: A pin with no active alternate function follows its GPIO registers. When register 1 (direction) has its bit at 1, the pin's `pin_oe_o` bit is 1 and its `pin_out_o` bit equals its bit of register 0 (data). When the direction bit is 0, `pin_oe_o` is 0.
- R3: When a pin's `pwm_en_i` bit is 1 and the request function does not own the pin, that pin's `pin_oe_o` is 1 and its `pin_out_o` equals its `pwm_lvl_i` bit, whatever its direction and data bits hold.
- R4: When bit 0 of register 5 (control) is 1, pin IRQ_PIN (default 7) is an input (`pin_oe_o` bit 0), whatever its PWM enable and direction bits hold. `irq_req_o` is then 1 exactly when that pin's synchronized level is 0. With control bit 0 at 0, `irq_req_o` is 0.
- R5: A read of register 0 returns, for each bit, the data register bit if its direction bit is 1, and otherwise the pin level seen two clock edges earlier.
- R6: Register 3 (polarity) selects the edge for each pin: 1 means rising and 0 means falling. A selected edge on `pin_in_i` sets that pin's bit in register 4 (flags) at the third clock edge after the input changes. The flag then stays set until software writes 1 to that bit of register 4. Writing 0 leaves the bit unchanged.
- R7: `pin_irq_o` is the OR over all pins of flag AND enable, where the enables are held in register 2. Edges are detected on a pin that is configured as an output as well.
- R8: While bit 2 of register 5 is 1, `trig_o` equals the synchronized level of pin TRIG_PIN (default 6); otherwise `trig_o` is 0. This routing never changes that pin's `pin_oe_o` or `pin_out_o`.
- R9: A 1 on `oc_event_i` sets the over-current flag, which reads back as bit 0 of register 6 and is cleared by writing 1 there. While this flag is set, `pin_out_o` of pin SUPPLY_PIN (default 0) is 0. `oc_irq_o` equals the flag AND bit 1 of register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 data, 1 direction, 2 enable, 3 polarity, 4 flags, 5 control, 6 over-current status) |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Register read data (combinational; unmapped addresses read 0) |
| pwm_en_i | input | NPINS | Per-pin PWM channel enable |
| pwm_lvl_i | input | NPINS | Per-pin PWM output level |
| pin_in_i | input | NPINS | Pad input levels (asynchronous) |
| oc_event_i | input | 1 | Over-current event on the supply pin |
| pin_out_o | output | NPINS | Per-pin output value |
| pin_oe_o | output | NPINS | Per-pin output enable |
| pin_irq_o | output | 1 | Combined pin-edge interrupt |
| irq_req_o | output | 1 | Interrupt request taken from the claimed pin |
| trig_o | output | 1 | Trigger forwarded from the routed pin |
| oc_irq_o | output | 1 | Over-current interrupt |

## Verification
The bound checker looks at the pin-ownership rules on every clock edge. It checks that the request function keeps its pin an input, that an enabled PWM channel drives its pin, and that a latched over-current holds the supply pin low. It also checks that a pin flag drops only after a write of 1 to that bit, and that both interrupt outputs are quiet just after reset. Other behaviour depends on time or on the input history, so only the bench scenarios can show it. This covers the two-edge read-back delay, the exact edge at which a selected edge sets a flag, a wrong-polarity edge leaving the flag clear, edge detection on an output pin, and trigger routing leaving the pin's drive untouched.

// File: rtl/gpio_mux_pkg.sv
// Package: shared register map and control-bit positions for the shared-pin GPIO port.
// Assumes: one register port with a 3-bit word address.
package gpio_mux_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_DATA = 3'd0,
        RA_DIR  = 3'd1,
        RA_IE   = 3'd2,
        RA_POL  = 3'd3,
        RA_FLAG = 3'd4,
        RA_CTRL = 3'd5,
        RA_OCST = 3'd6
    } reg_addr_e;

    localparam int CTRL_IRQ_EN  = 0;
    localparam int CTRL_OC_IE   = 1;
    localparam int CTRL_TRIG_EN = 2;
    localparam int CTRL_W       = 3;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes: every bit is an independent level; STAGES >= 2; reset clears the chain to 0.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage captures the raw pad level
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q[0] <= '0;
                else         chain_q[0] <= async_i;
            end
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q[s] <= '0;
                else         chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
// Module: per-pin edge detector with selectable polarity and sticky write-1-to-clear flags.
// Assumes: sync_i is already in the clock domain; a set and a clear in the same cycle leave the flag set.
module gpio_edge_flags #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    // remember last synchronized level for edge comparison
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= sync_i;
    end

    // select rising or falling edge per pin
    always_comb begin
        for (int i = 0; i < W; i++) begin
            hit[i] = pol_i[i] ? (sync_i[i] & ~prev_q[i]) : (~sync_i[i] & prev_q[i]);
        end
    end

    // sticky flags: edge sets, software write of 1 clears
    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_o <= '0;
        else         flag_o <= hit | (flag_o & ~clr_i);
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: per-pin ownership arbiter; request input over PWM over GPIO, plus over-current pull-low.
// Assumes: IRQ_PIN and SUPPLY_PIN are valid pin indices; purely combinational.
module gpio_pin_mux #(
    parameter int W          = 8,
    parameter int IRQ_PIN    = 7,
    parameter int SUPPLY_PIN = 0
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] pwm_en_i,
    input  logic [W-1:0] pwm_lvl_i,
    input  logic         irq_fn_en_i,
    input  logic         oc_force_i,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic own_out;
        logic own_oe;
        if (i == IRQ_PIN) begin : g_irq
            // request function forces this pin to input
            always_comb begin
                if (irq_fn_en_i)      begin own_oe = 1'b0; own_out = 1'b0;         end
                else if (pwm_en_i[i]) begin own_oe = 1'b1; own_out = pwm_lvl_i[i]; end
                else                  begin own_oe = dir_i[i]; own_out = data_i[i]; end
            end
        end else begin : g_plain
            // PWM wins over GPIO
            always_comb begin
                if (pwm_en_i[i]) begin own_oe = 1'b1; own_out = pwm_lvl_i[i]; end
                else             begin own_oe = dir_i[i]; own_out = data_i[i]; end
            end
        end
        if (i == SUPPLY_PIN) begin : g_sup
            assign out_o[i] = own_out & ~oc_force_i;
        end else begin : g_nsup
            assign out_o[i] = own_out;
        end
        assign oe_o[i] = own_oe;
    end
endmodule

// File: rtl/gpio_mux_port.sv
// Module: top of the shared-pin GPIO port: register file, read-back mux, synchronizer,
// edge flags, trigger routing, over-current latch and pin arbitration.
// Assumes: register port is single-cycle, writes at clock edge, reads combinational.
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int IRQ_PIN     = 7,
    parameter int TRIG_PIN    = 6,
    parameter int SUPPLY_PIN  = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [NPINS-1:0]  reg_wdata_i,
    output logic [NPINS-1:0]  reg_rdata_o,
    input  logic [NPINS-1:0]  pwm_en_i,
    input  logic [NPINS-1:0]  pwm_lvl_i,
    input  logic [NPINS-1:0]  pin_in_i,
    input  logic              oc_event_i,
    output logic [NPINS-1:0]  pin_out_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              pin_irq_o,
    output logic              irq_req_o,
    output logic              trig_o,
    output logic              oc_irq_o
);
    localparam int PADW = NPINS - CTRL_W;

    logic [NPINS-1:0]  data_q, dir_q, ie_q, pol_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              oc_flag_q;
    logic [NPINS-1:0]  pin_sync, pin_flag, flag_clr;
    reg_addr_e         addr;
    logic              ctrl_irq_en;

    assign addr        = reg_addr_e'(reg_addr_i);
    assign ctrl_irq_en = ctrl_q[CTRL_IRQ_EN];

    // configuration registers written by software
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            data_q <= '0;
            dir_q  <= '0;
            ie_q   <= '0;
            pol_q  <= '0;
            ctrl_q <= '0;
        end else if (reg_we_i) begin
            case (addr)
                RA_DATA: data_q <= reg_wdata_i;
                RA_DIR:  dir_q  <= reg_wdata_i;
                RA_IE:   ie_q   <= reg_wdata_i;
                RA_POL:  pol_q  <= reg_wdata_i;
                RA_CTRL: ctrl_q <= reg_wdata_i[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    // over-current latch: event sets, write of 1 clears, set wins
    always_ff @(posedge clk_i) begin
        if (!rst_ni) oc_flag_q <= 1'b0;
        else if (oc_event_i) oc_flag_q <= 1'b1;
        else if (reg_we_i && addr == RA_OCST && reg_wdata_i[0]) oc_flag_q <= 1'b0;
    end

    // flag clear mask from a write to the flag register
    assign flag_clr = (reg_we_i && addr == RA_FLAG) ? reg_wdata_i : '0;

    gpio_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_in_i),
        .sync_o  (pin_sync)
    );

    gpio_edge_flags #(
        .W (NPINS)
    ) i_edges (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (pin_sync),
        .pol_i  (pol_q),
        .clr_i  (flag_clr),
        .flag_o (pin_flag)
    );

    gpio_pin_mux #(
        .W          (NPINS),
        .IRQ_PIN    (IRQ_PIN),
        .SUPPLY_PIN (SUPPLY_PIN)
    ) i_mux (
        .dir_i       (dir_q),
        .data_i      (data_q),
        .pwm_en_i    (pwm_en_i),
        .pwm_lvl_i   (pwm_lvl_i),
        .irq_fn_en_i (ctrl_irq_en),
        .oc_force_i  (oc_flag_q),
        .out_o       (pin_out_o),
        .oe_o        (pin_oe_o)
    );

    // register read-back; data reads pin level for input bits
    always_comb begin
        case (addr)
            RA_DATA: reg_rdata_o = (data_q & dir_q) | (pin_sync & ~dir_q);
            RA_DIR:  reg_rdata_o = dir_q;
            RA_IE:   reg_rdata_o = ie_q;
            RA_POL:  reg_rdata_o = pol_q;
            RA_FLAG: reg_rdata_o = pin_flag;
            RA_CTRL: reg_rdata_o = {{PADW{1'b0}}, ctrl_q};
            RA_OCST: reg_rdata_o = {{(NPINS-1){1'b0}}, oc_flag_q};
            default: reg_rdata_o = '0;
        endcase
    end

    assign pin_irq_o = |(pin_flag & ie_q);
    assign irq_req_o = ctrl_irq_en & ~pin_sync[IRQ_PIN];
    assign trig_o    = ctrl_q[CTRL_TRIG_EN] & pin_sync[TRIG_PIN];
    assign oc_irq_o  = oc_flag_q & ctrl_q[CTRL_OC_IE];
endmodule

// File: rtl/gpio_mux_port_chk.sv
// Module: assertion checker for gpio_mux_port, attached by bind below.
// Assumes: sees the top's ports plus its control, flag and over-current state.
module gpio_mux_port_chk
    import gpio_mux_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int IRQ_PIN    = 7,
    parameter int SUPPLY_PIN = 0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_we_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [NPINS-1:0]  reg_wdata_i,
    input logic [NPINS-1:0]  pwm_en_i,
    input logic [NPINS-1:0]  pwm_lvl_i,
    input logic [NPINS-1:0]  pin_out_o,
    input logic [NPINS-1:0]  pin_oe_o,
    input logic              pin_irq_o,
    input logic              oc_irq_o,
    input logic              irq_fn_en,
    input logic              oc_flag,
    input logic [NPINS-1:0]  pin_flag
);
    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> (!pin_irq_o && !oc_irq_o)); // R1

    AST_IRQ_PIN_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_fn_en |-> !pin_oe_o[IRQ_PIN]); // R4

    AST_OC_SUPPLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oc_flag |-> !pin_out_o[SUPPLY_PIN]); // R9

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (i != IRQ_PIN && i != SUPPLY_PIN) begin : g_pwm
            AST_PWM_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
                pwm_en_i[i] |-> (pin_oe_o[i] && pin_out_o[i] == pwm_lvl_i[i])); // R3
        end
        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(pin_flag[i]) |-> (!$past(rst_ni) ||
                $past(reg_we_i && reg_addr_i == RA_FLAG && reg_wdata_i[i]))); // R6
    end
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .NPINS      (NPINS),
    .IRQ_PIN    (IRQ_PIN),
    .SUPPLY_PIN (SUPPLY_PIN)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .pwm_en_i    (pwm_en_i),
    .pwm_lvl_i   (pwm_lvl_i),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .pin_irq_o   (pin_irq_o),
    .oc_irq_o    (oc_irq_o),
    .irq_fn_en   (ctrl_irq_en),
    .oc_flag     (oc_flag_q),
    .pin_flag    (pin_flag)
);

// File: tb/test_gpio_mux_port.sv
// Bench: random pin-ownership and read-back rounds plus directed edge, trigger and over-current cases.
module test_gpio_mux_port;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       we = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic [7:0] pwm_en = 0, pwm_lvl = 0, pin_in = 0;
    logic       oc_ev = 0;
    logic [7:0] pout, poe;
    logic       pirq, ireq, trig, ocirq;
    int         checks = 0, fails = 0;

    logic [7:0] m_data, m_dir;
    logic       m_irq_en, m_trig_en;

    always #5 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pwm_en_i(pwm_en),
        .pwm_lvl_i(pwm_lvl), .pin_in_i(pin_in), .oc_event_i(oc_ev),
        .pin_out_o(pout), .pin_oe_o(poe), .pin_irq_o(pirq), .irq_req_o(ireq),
        .trig_o(trig), .oc_irq_o(ocirq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected {oe,out} of one pin from the ownership rules
    function automatic logic [1:0] exp_pin(input int i);
        if (i == 7 && m_irq_en) return 2'b00;
        if (pwm_en[i])          return {1'b1, pwm_lvl[i]};
        return {m_dir[i], m_dir[i] & m_data[i]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h1234_5a5a));
        waitn(3);
        // R1 reset state, still in reset
        chk(poe == 0, "R1 oe in reset", poe, 0);
        @(negedge clk); rst_n = 1;
        rd(1, r); chk(r == 0, "R1 dir after reset", r, 0);
        rd(4, r); chk(r == 0, "R1 flags after reset", r, 0);
        rd(6, r); chk(r == 0, "R1 oc flag after reset", r, 0);
        chk(!pirq && !ocirq, "R1 irq outputs", {pirq, ocirq}, 0);

        // random ownership and read-back rounds
        for (int k = 0; k < 40; k++) begin
            m_data = 8'($urandom); m_dir = 8'($urandom);
            m_irq_en = 1'($urandom); m_trig_en = 1'($urandom);
            if (k < 4) begin m_irq_en = 1; end
            wr(0, m_data); wr(1, m_dir); wr(5, {5'd0, m_trig_en, 1'b0, m_irq_en});
            @(negedge clk);
            pwm_en = (k % 3 == 0) ? 8'hFF : 8'($urandom); pwm_lvl = 8'($urandom);
            pin_in = 8'($urandom);
            waitn(3);
            for (int i = 0; i < 8; i++) begin
                logic [1:0] e;
                e = exp_pin(i);
                if (i == 7 && m_irq_en)
                    chk({poe[i], pout[i]} == e, "R4 irq pin forced input", {poe[i], pout[i]}, e);
                else if (pwm_en[i])
                    chk({poe[i], pout[i]} == e, "R3 pwm drives pin", {poe[i], pout[i]}, e);
                else
                    chk(poe[i] == e[1] && (!e[1] || pout[i] == e[0]), "R2 gpio drive",
                        {poe[i], pout[i]}, e);
            end
            chk(ireq == (m_irq_en & ~pin_in[7]), "R4 irq_req level", ireq, m_irq_en & ~pin_in[7]);
            chk(trig == (m_trig_en & pin_in[6]), "R8 trigger follows pin", trig, m_trig_en & pin_in[6]);
            rd(0, r);
            chk(r == ((m_dir & m_data) | (~m_dir & pin_in)), "R5 data read-back", r,
                (m_dir & m_data) | (~m_dir & pin_in));
        end

        // R5 two-edge delay: new input invisible after one edge, visible after two
        wr(1, 8'h00); addr = 0;
        @(negedge clk); pin_in = 8'h00; waitn(3);
        @(negedge clk); pin_in = 8'hA5;
        @(negedge clk); #1 chk(rdata == 8'h00, "R5 one edge stale", rdata, 0);
        @(negedge clk); #1 chk(rdata == 8'hA5, "R5 two edges visible", rdata, 8'hA5);

        // edge flags setup
        pwm_en = 0; wr(5, 0); wr(1, 0); pin_in = 0; waitn(4);
        wr(4, 8'hFF); wr(3, 8'h04); wr(2, 8'h04);
        // R6 rising edge on pin 2 sets flag on the third edge
        @(negedge clk); pin_in[2] = 1; addr = 4;
        @(negedge clk); @(negedge clk); #1
        chk(rdata[2] == 0, "R6 flag not yet after two edges", rdata, 0);
        @(negedge clk); #1
        chk(rdata[2] == 1, "R6 rising edge flag", rdata, 8'h04);
        chk(pirq == 1, "R7 irq from enabled flag", pirq, 1);
        // R6 falling edge on rising-polarity pin ignored after clear
        wr(4, 8'h04); pin_in[2] = 0; waitn(4);
        rd(4, r); chk(r[2] == 0, "R6 wrong polarity ignored", r, 0);
        // R6 falling polarity on pin 3, write-0 keeps, write-1 clears
        pin_in[3] = 1; waitn(4); wr(4, 8'hFF);
        pin_in[3] = 0; waitn(4);
        rd(4, r); chk(r[3] == 1, "R6 falling edge flag", r[3], 1);
        chk(pirq == 0, "R7 flag without enable no irq", pirq, 0);
        wr(4, 8'h00); rd(4, r); chk(r[3] == 1, "R6 write 0 keeps flag", r[3], 1);
        wr(4, 8'h08); rd(4, r); chk(r[3] == 0, "R6 write 1 clears flag", r[3], 0);

        // R7 edge detected on an output pin
        wr(1, 8'h04); wr(0, 8'h00); wr(4, 8'hFF);
        pin_in[2] = 1; waitn(4);
        chk(pirq == 1, "R7 output-mode pin raises irq", pirq, 1);
        wr(4, 8'hFF); wr(2, 0); wr(1, 0);

        // R8 trigger routing leaves pin 6 drive untouched
        wr(1, 8'h40); wr(0, 8'h00); wr(5, 8'h04);
        pin_in[6] = 1; waitn(3);
        chk(trig == 1, "R8 trigger high", trig, 1);
        chk(poe[6] == 1 && pout[6] == 0, "R8 pin drive unchanged", {poe[6], pout[6]}, 2'b10);

        // R9 over-current latch
        wr(1, 8'h01); wr(0, 8'h01); wr(5, 8'h02);
        chk(pout[0] == 1, "R9 supply pin driven before event", pout[0], 1);
        @(negedge clk); oc_ev = 1; @(negedge clk); oc_ev = 0;
        chk(pout[0] == 0, "R9 supply pin forced low", pout[0], 0);
        chk(ocirq == 1, "R9 over-current irq", ocirq, 1);
        waitn(3);
        rd(6, r); chk(r == 8'h01, "R9 flag sticky", r, 1);
        wr(6, 8'h01);
        chk(pout[0] == 1 && ocirq == 0, "R9 cleared releases pin", {pout[0], ocirq}, 2'b10);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule